// File: doc/BRIEF.md
# Feature-Weight Matrix Multiplier

This block multiplies a node feature matrix of 6 rows by 96 columns with a weight matrix of 96 rows by 3 columns. The result is a 6x3 matrix of dot products, which a later graph stage consumes. All operands are unsigned 5-bit values. The block reads them from an external memory through a single read port. Each read returns one whole 96-value vector: either a weight column or a feature row.

After a start pulse the block fetches the three weight columns and keeps them in registers. It then computes the result elements one at a time in row-major order. For each element it spends one cycle requesting the feature row and one cycle forming the full dot product. Ninety-six multipliers feeding a single summation do that work. When the last element has been stored, a one-cycle done pulse is raised and the result array holds until the next run.

Top module: `fw_matmul`

## Requirements
- R1: A synchronous active-high reset leaves done low, readEn low and every result element zero in the cycle after the reset edge. This holds even if a computation was in progress.
- R2: The clock edge that samples start high while the block is idle starts a run. In the three cycles after that edge, readEn is high with readAddr equal to 0, 1 and 2 (weight columns 0, 1, 2), in that order.
- R3: After the weight reads come feature-row reads at address 512 + r. There is one read per result element, in row-major order: row r is requested three times before row r+1. Every read address lies either in 0..2 or in 512..517.
- R4: Result element (r,c) equals the unsigned sum over f of feature[r][f] times weight[f][c]. It is held in 17 bits, so the all-ones operand case (96 x 31 x 31 = 92256) is exact.
- R5: Element (r,c) appears on result bits [(r*3+c)*17 +: 17].
- R6: done is high for exactly one cycle. It is visible after the 40th rising edge following the edge that sampled start, and low after the 41st.
- R7: A start pulse while a run is in progress has no effect. The run keeps its timing and its 21 reads, and no further read or done follows it.
- R8: While done is high and whenever the block is idle, readEn is low. Feature reads never occur on two consecutive cycles.
- R9: Read data is taken one cycle after the cycle in which readEn was high. Memory returns rdData on the clock edge that ends the enable cycle, and the element of vector position f sits at rdData[f*5 +: 5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| reset | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| rdData | input | 480 | Memory read vector, 96 x 5-bit values |
| readAddr | output | 13 | Memory read address |
| readEn | output | 1 | Memory read strobe |
| done | output | 1 | One-cycle completion pulse |
| result | output | 306 | 18 x 17-bit result elements, row-major |

## Verification
The bench releases start at a falling edge and then counts falling edges. done must appear at count 40 and disappear at count 41. Read requests are logged at the rising edge at which they are taken, so the order of the 21 addresses is compared without reference to timing. Result elements are read only after done has been seen, when all 18 writes are certain to have landed. Their values are compared with a product sum computed in the bench from the same operand functions that fill the memory model.

// File: rtl/fw_matmul_pkg.sv
package fw_matmul_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             loadW;
    logic [IDX_W-1:0] wIdx;
    logic             writeRes;
    logic [IDX_W-1:0] rIdx;
    logic [IDX_W-1:0] cIdx;
  } mmCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WLOAD = 2'd1,
    ST_RUN   = 2'd2
  } mmState_t;
endpackage

// File: rtl/fw_matmul_ctrl.sv
module fw_matmul_ctrl
  import fw_matmul_pkg::*;
#(
  parameter int ROWS      = 6,
  parameter int COLS      = 3,
  parameter int AW        = 13,
  parameter int FEAT_BASE = 512
) (
  input  logic          clk,
  input  logic          reset,
  input  logic          start,
  output logic          readEn,
  output logic [AW-1:0] readAddr,
  output logic          done,
  output mmCtl_t        ctl
);
  mmState_t state;
  logic [IDX_W-1:0] wCnt;
  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] colIdx;
  logic             phase;

  always_ff @(posedge clk) begin
    if (reset) begin
      state  <= ST_IDLE;
      wCnt   <= '0;
      rowIdx <= '0;
      colIdx <= '0;
      phase  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_WLOAD;
            wCnt  <= '0;
          end
        end
        ST_WLOAD: begin
          wCnt <= wCnt + 1'b1;
          if (wCnt == IDX_W'(COLS)) begin
            state  <= ST_RUN;
            rowIdx <= '0;
            colIdx <= '0;
            phase  <= 1'b0;
          end
        end
        ST_RUN: begin
          phase <= ~phase;
          if (phase) begin
            if (colIdx == IDX_W'(COLS - 1)) begin
              colIdx <= '0;
              if (rowIdx == IDX_W'(ROWS - 1)) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                rowIdx <= rowIdx + 1'b1;
              end
            end else begin
              colIdx <= colIdx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    readEn   = 1'b0;
    readAddr = '0;
    ctl      = '0;
    case (state)
      ST_WLOAD: begin
        if (wCnt < IDX_W'(COLS)) begin
          readEn   = 1'b1;
          readAddr = AW'(wCnt);
        end
        if (wCnt != '0) begin
          ctl.loadW = 1'b1;
          ctl.wIdx  = wCnt - 1'b1;
        end
      end
      ST_RUN: begin
        if (!phase) begin
          readEn   = 1'b1;
          readAddr = AW'(FEAT_BASE) + AW'(rowIdx);
        end else begin
          ctl.writeRes = 1'b1;
          ctl.rIdx     = rowIdx;
          ctl.cIdx     = colIdx;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fw_matmul_dot.sv
module fw_matmul_dot #(
  parameter int FEATS = 96,
  parameter int DW    = 5,
  parameter int ACCW  = 17
) (
  input  logic [FEATS*DW-1:0] aVec,
  input  logic [FEATS*DW-1:0] bVec,
  output logic [ACCW-1:0]     sum
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod [FEATS];

  for (genvar f = 0; f < FEATS; f++) begin : g_mul
    assign prod[f] = PW'(aVec[f*DW +: DW]) * PW'(bVec[f*DW +: DW]);
  end

  always_comb begin
    sum = '0;
    for (int f = 0; f < FEATS; f++) begin
      sum = sum + ACCW'(prod[f]);
    end
  end
endmodule

// File: rtl/fw_matmul_datapath.sv
module fw_matmul_datapath
  import fw_matmul_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int COLS  = 3,
  parameter int FEATS = 96,
  parameter int DW    = 5,
  parameter int ACCW  = 17
) (
  input  logic                    clk,
  input  logic                    reset,
  input  mmCtl_t                  ctl,
  input  logic [FEATS*DW-1:0]     rdData,
  output logic [ROWS*COLS*ACCW-1:0] result
);
  localparam int VW = FEATS * DW;

  logic [VW-1:0]   wReg [COLS];
  logic [VW-1:0]   wSel;
  logic [ACCW-1:0] dotSum;

  for (genvar c = 0; c < COLS; c++) begin : g_wreg
    always_ff @(posedge clk) begin
      if (reset) begin
        wReg[c] <= '0;
      end else if (ctl.loadW && ctl.wIdx == IDX_W'(c)) begin
        wReg[c] <= rdData;
      end
    end
  end

  always_comb begin
    wSel = '0;
    for (int c = 0; c < COLS; c++) begin
      if (ctl.cIdx == IDX_W'(c)) wSel = wReg[c];
    end
  end

  fw_matmul_dot #(.FEATS(FEATS), .DW(DW), .ACCW(ACCW)) i_dot (
    .aVec(rdData),
    .bVec(wSel),
    .sum (dotSum)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (reset) begin
          result[(r*COLS+c)*ACCW +: ACCW] <= '0;
        end else if (ctl.writeRes && ctl.rIdx == IDX_W'(r) && ctl.cIdx == IDX_W'(c)) begin
          result[(r*COLS+c)*ACCW +: ACCW] <= dotSum;
        end
      end
    end
  end
endmodule

// File: rtl/fw_matmul.sv
module fw_matmul
  import fw_matmul_pkg::*;
#(
  parameter int ROWS      = 6,
  parameter int COLS      = 3,
  parameter int FEATS     = 96,
  parameter int DW        = 5,
  parameter int AW        = 13,
  parameter int FEAT_BASE = 512,
  localparam int ACCW     = 2 * DW + $clog2(FEATS),
  localparam int VW       = FEATS * DW,
  localparam int RW       = ROWS * COLS * ACCW
) (
  input  logic          clk,
  input  logic          reset,
  input  logic          start,
  input  logic [VW-1:0] rdData,
  output logic [AW-1:0] readAddr,
  output logic          readEn,
  output logic          done,
  output logic [RW-1:0] result
);
  mmCtl_t ctl;

  fw_matmul_ctrl #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .FEAT_BASE(FEAT_BASE)) i_ctrl (
    .clk     (clk),
    .reset   (reset),
    .start   (start),
    .readEn  (readEn),
    .readAddr(readAddr),
    .done    (done),
    .ctl     (ctl)
  );

  fw_matmul_datapath #(.ROWS(ROWS), .COLS(COLS), .FEATS(FEATS), .DW(DW), .ACCW(ACCW)) i_dp (
    .clk   (clk),
    .reset (reset),
    .ctl   (ctl),
    .rdData(rdData),
    .result(result)
  );
endmodule

// File: rtl/fw_matmul_checker.sv
module fw_matmul_checker #(
  parameter int AW        = 13,
  parameter int COLS      = 3,
  parameter int ROWS      = 6,
  parameter int FEAT_BASE = 512,
  parameter int RW        = 306
) (
  input logic          clk,
  input logic          reset,
  input logic          readEn,
  input logic [AW-1:0] readAddr,
  input logic          done,
  input logic [RW-1:0] result
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    reset |=> (!done && result == '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (reset)
    done |=> !done);

  assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (reset)
    done |-> !readEn);

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (reset)
    readEn |-> (readAddr < AW'(COLS) ||
                (readAddr >= AW'(FEAT_BASE) && readAddr < AW'(FEAT_BASE + ROWS))));

  assert_feat_spacing_R8: assert property (@(posedge clk) disable iff (reset)
    (readEn && readAddr >= AW'(FEAT_BASE)) |=> !readEn);
endmodule

bind fw_matmul fw_matmul_checker #(
  .AW(AW), .COLS(COLS), .ROWS(ROWS), .FEAT_BASE(FEAT_BASE), .RW(RW)
) i_chk (
  .clk     (clk),
  .reset   (reset),
  .readEn  (readEn),
  .readAddr(readAddr),
  .done    (done),
  .result  (result)
);

// File: tb/test_fw_matmul.sv
module test_fw_matmul;
  localparam int PERIOD = 10;
  localparam int ROWS = 6, COLS = 3, FEATS = 96, DW = 5, AW = 13, FEAT_BASE = 512;
  localparam int ACCW = 17;
  localparam int VW = FEATS * DW;
  localparam int RW = ROWS * COLS * ACCW;
  localparam int NPAT = 4;
  localparam int PAT_MODE [NPAT] = '{0, 1, 2, 3};
  localparam bit PAT_POKE [NPAT] = '{1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic start = 1'b0;
  logic [VW-1:0] rdData = '0;
  logic [AW-1:0] readAddr;
  logic readEn;
  logic done;
  logic [RW-1:0] result;

  int errors = 0;
  int checks = 0;
  int curMode = 0;
  int nReads = 0;
  int addrLog [64];

  always #(PERIOD/2) clk = ~clk;

  fw_matmul i_fw_matmul (
    .clk(clk), .reset(reset), .start(start), .rdData(rdData),
    .readAddr(readAddr), .readEn(readEn), .done(done), .result(result)
  );

  function automatic int featVal(int mode, int r, int f);
    case (mode)
      0: return (r * 11 + f * 3 + 1) % 32;
      1: return 31;
      2: return (f % (r + 2) == 0) ? (r + f % 5 + 1) : 0;
      default: return (r == ROWS - 1) ? 31 : 0;
    endcase
  endfunction

  function automatic int wtVal(int mode, int c, int f);
    case (mode)
      0: return (c * 5 + f * 7 + 2) % 32;
      1: return 31;
      2: return (f == c * 30) ? 31 : ((f % 4 == c) ? 1 : 0);
      default: return (c == 1) ? 31 : 0;
    endcase
  endfunction

  function automatic logic [VW-1:0] memWord(int mode, int addr);
    logic [VW-1:0] w = '0;
    for (int f = 0; f < FEATS; f++) begin
      if (addr < COLS) w[f*DW +: DW] = DW'(wtVal(mode, addr, f));
      else if (addr >= FEAT_BASE && addr < FEAT_BASE + ROWS)
        w[f*DW +: DW] = DW'(featVal(mode, addr - FEAT_BASE, f));
    end
    return w;
  endfunction

  function automatic int refDot(int mode, int r, int c);
    int s = 0;
    for (int f = 0; f < FEATS; f++) s += featVal(mode, r, f) * wtVal(mode, c, f);
    return s;
  endfunction

  // memory model (R9): data returned on the edge that ends the enable cycle
  always @(posedge clk) begin
    if (readEn) begin
      rdData <= memWord(curMode, int'(readAddr));
      if (nReads < 64) addrLog[nReads] = int'(readAddr);
      nReads = nReads + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runGraph(input int mode, input bit poke);
    int lat = 0;
    curMode = mode;
    @(negedge clk);
    nReads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
      start = poke && (lat == 10);
    end
    start = 1'b0;
    check(lat == 40, "R6 done latency", lat, 40);
    check(nReads == 21, "R7 read count", nReads, 21);
    for (int i = 0; i < COLS; i++)
      check(addrLog[i] == i, "R2 weight address", addrLog[i], i);
    for (int k = 0; k < ROWS * COLS; k++)
      check(addrLog[COLS + k] == FEAT_BASE + k / COLS, "R3 feature address",
            addrLog[COLS + k], FEAT_BASE + k / COLS);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int got = int'(result[(r*COLS+c)*ACCW +: ACCW]);
        check(got == refDot(mode, r, c), "R4 R5 R9 element value", got, refDot(mode, r, c));
      end
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", int'(done), 0);
    if (poke) begin
      bit sawAct = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (done || readEn) sawAct = 1'b1;
      end
      check(!sawAct, "R7 no follow-up run", int'(sawAct), 0);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reset = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(readEn == 1'b0, "R1 readEn after reset", int'(readEn), 0);
    check(result == '0, "R1 result after reset", 0, 0);
    check(readEn == 1'b0, "R8 idle quiet", int'(readEn), 0);

    for (int p = 0; p < NPAT; p++) runGraph(PAT_MODE[p], PAT_POKE[p]);

    // R4 boundary: all-ones operands give the largest sum
    check(refDot(1, 0, 0) == 92256, "R4 max reference", refDot(1, 0, 0), 92256);

    // R1: reset during a run clears results and stops activity
    curMode = 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    reset = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 mid-run done", int'(done), 0);
    check(readEn == 1'b0, "R1 mid-run readEn", int'(readEn), 0);
    check(result == '0, "R1 mid-run result cleared", 0, 0);
    reset = 1'b0;
    @(negedge clk);
    runGraph(0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule